// File: doc/BRIEF.md
# Erased Page Zero-Bit Screen

This block runs after a multi-bit error-correcting decoder has given up on a 512-byte codeword. Such a failure often comes from a page that was never programmed. In that case every bit of both the data and the stored check bytes should read as one, but the decoder still rejects the page, because the check value of an all-ones message is not itself all ones. The block streams the codeword once, one byte per cycle. It keeps one tally of zero bits for data bytes and a separate tally for check bytes, and it decides whether the page is an erased page with a few flipped bits or a real uncorrectable codeword.

A session opens with a start pulse, and only when the decoder's reported error count is above the threshold (8 by default). A valid strobe qualifies each byte, a check-byte flag marks whether the byte belongs to the stored check field, and a last strobe marks the final byte. Each tally saturates once it passes the threshold. As soon as the two tallies together exceed the threshold, the session ends early and the codeword is flagged uncorrectable. Otherwise the block reports the number of zero bits found in the data bytes, and it asks for the data buffer to be rewritten with 0xFF when that number is nonzero.

Top module: `eras_detect`

## Requirements
- R1: After reset, done_o, uncorr_o and fill_o are low and flips_o is zero.
- R2: A start pulse opens a session only when dec_err_i is greater than 8. A start with dec_err_i of 8 or less is ignored: later bytes produce no done_o, and the held results do not change.
- R3: Each accepted byte adds its number of zero bits, which is 8 minus its count of ones, to one tally (0x5A adds 4, 0x00 adds 8, 0xFF adds 0).
- R4: Bytes with is_check_i high go to the check tally and the others go to the data tally. flips_o reports the data tally only.
- R5: When byte_last_i is accepted and the two tallies sum to at most 8, done_o pulses in the next cycle with uncorr_o low and flips_o equal to the data zero count.
- R6: fill_o (the request to write 0xFF into all data bytes) is high exactly when the page is judged erased and the data zero count is nonzero.
- R7: When the sum of the tallies first exceeds 8, done_o pulses in the cycle after that byte, even if it is not the last byte, with uncorr_o high, fill_o low and flips_o zero.
- R8: Once done_o has pulsed, further bytes are ignored until the next accepted start, and uncorr_o, fill_o and flips_o hold their values.
- R9: An accepted start clears both tallies and the held results, including in the middle of a session.
- R10: done_o is high for exactly one cycle per session.
- R11: A sum of exactly 8 zero bits is still judged erased.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Session start pulse |
| dec_err_i | input | 4 | Error count reported by the decoder, compared at start |
| byte_valid_i | input | 1 | Byte strobe |
| byte_i | input | 8 | Streamed byte |
| is_check_i | input | 1 | High for stored check bytes, low for data bytes |
| byte_last_i | input | 1 | Final byte of the codeword |
| done_o | output | 1 | One-cycle result pulse |
| uncorr_o | output | 1 | Codeword is uncorrectable |
| fill_o | output | 1 | Request to overwrite all data bytes with 0xFF |
| flips_o | output | 4 | Data zero-bit count of an erased page |

## Verification
A tally fed to the wrong lane shows up at the ports as a wrong flips_o or a wrong fill_o on the very next done_o, so the bench puts its zero bits in check bytes and data bytes on their own. A tally that saturates wrongly, or a sum that is compared wrongly, moves the early-exit done_o by one or more byte positions, or flips the verdict at the 8 and 9 boundary. The bench therefore records the exact byte index after which done_o appears. A state machine that does not close after done_o produces a second pulse or changed results on the trailing bytes, which the bench counts until the stream ends.

// File: rtl/eras_pkg.sv
package eras_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } eras_state_e;

  localparam int LANE_DATA = 0;
  localparam int LANE_CHK  = 1;
  localparam int N_LANES   = 2;

endpackage

// File: rtl/eras_zero_pop.sv
module eras_zero_pop #(
  parameter int BYTE_W = 8,
  parameter int POP_W  = 4
) (
  input  logic [BYTE_W-1:0] byte_i,
  output logic [POP_W-1:0]  zeros_o
);

  // count of cleared bits in the incoming byte
  always_comb begin
    zeros_o = '0;
    for (int b = 0; b < BYTE_W; b++) begin
      zeros_o = zeros_o + POP_W'(~byte_i[b]);
    end
  end

endmodule

// File: rtl/eras_tally.sv
module eras_tally #(
  parameter int POP_W = 4,
  parameter int CNT_W = 4,
  parameter int CAP   = 9
) (
  input  logic             clk_i,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             add_en_i,
  input  logic [POP_W-1:0] add_i,
  output logic [CNT_W-1:0] cnt_nxt_o
);

  localparam int SUM_W = ((CNT_W > POP_W) ? CNT_W : POP_W) + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [SUM_W-1:0] sum;
  logic             upd;

  assign sum = SUM_W'(cnt_q) + SUM_W'(add_i);
  assign upd = clr_i | add_en_i;

  // next value: clear wins, then a saturating add
  always_comb begin
    if (clr_i) begin
      cnt_nxt_o = '0;
    end else if (add_en_i) begin
      if (sum >= SUM_W'(CAP)) begin
        cnt_nxt_o = CNT_W'(CAP);
      end else begin
        cnt_nxt_o = CNT_W'(sum);
      end
    end else begin
      cnt_nxt_o = cnt_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (upd) begin
      cnt_q <= cnt_nxt_o;
    end
  end

endmodule

// File: rtl/eras_verdict.sv
module eras_verdict #(
  parameter int CNT_W  = 4,
  parameter int THRESH = 8
) (
  input  logic [CNT_W-1:0] data_cnt_i,
  input  logic [CNT_W-1:0] chk_cnt_i,
  output logic             over_o,
  output logic             fill_o,
  output logic [CNT_W-1:0] flips_o
);

  logic [CNT_W:0] total;

  assign total   = (CNT_W+1)'(data_cnt_i) + (CNT_W+1)'(chk_cnt_i);
  assign over_o  = (32'(total) > THRESH);
  assign flips_o = over_o ? '0 : data_cnt_i;
  assign fill_o  = !over_o && (data_cnt_i != '0);

endmodule

// File: rtl/eras_detect.sv
module eras_detect #(
  parameter int BYTE_W = 8,
  parameter int THRESH = 8,
  parameter int DEC_W  = 4
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              start_i,
  input  logic [DEC_W-1:0]                  dec_err_i,
  input  logic                              byte_valid_i,
  input  logic [BYTE_W-1:0]                 byte_i,
  input  logic                              is_check_i,
  input  logic                              byte_last_i,
  output logic                              done_o,
  output logic                              uncorr_o,
  output logic                              fill_o,
  output logic [$clog2(THRESH+2)-1:0]       flips_o
);

  import eras_pkg::*;

  localparam int POP_W = $clog2(BYTE_W+1);
  localparam int CNT_W = $clog2(THRESH+2);
  localparam int CAP   = THRESH + 1;

  // reset: asserted asynchronously, released on the clock
  logic rst_meta, rst_n;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta <= 1'b0;
      rst_n    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_n    <= rst_meta;
    end
  end

  eras_state_e state_q, state_d;
  logic        start_acc, accept, finish;
  logic [POP_W-1:0] zeros;
  logic [CNT_W-1:0] cnt_nxt [N_LANES];
  logic        v_over, v_fill;
  logic [CNT_W-1:0] v_flips;

  logic             done_q, uncorr_q, fill_q;
  logic [CNT_W-1:0] flips_q;
  logic             done_d, uncorr_d, fill_d, res_en;
  logic [CNT_W-1:0] flips_d;

  assign start_acc = start_i && (32'(dec_err_i) > THRESH);
  assign accept    = (state_q == ST_RUN) && byte_valid_i && !start_acc;
  assign finish    = accept && (byte_last_i || v_over);

  eras_zero_pop #(.BYTE_W(BYTE_W), .POP_W(POP_W)) u_pop (
    .byte_i  (byte_i),
    .zeros_o (zeros)
  );

  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    logic lane_hit;
    assign lane_hit = (g == LANE_CHK) ? is_check_i : !is_check_i;
    eras_tally #(.POP_W(POP_W), .CNT_W(CNT_W), .CAP(CAP)) u_tally (
      .clk_i     (clk_i),
      .rst_n     (rst_n),
      .clr_i     (start_acc),
      .add_en_i  (accept && lane_hit),
      .add_i     (zeros),
      .cnt_nxt_o (cnt_nxt[g])
    );
  end

  eras_verdict #(.CNT_W(CNT_W), .THRESH(THRESH)) u_verdict (
    .data_cnt_i (cnt_nxt[LANE_DATA]),
    .chk_cnt_i  (cnt_nxt[LANE_CHK]),
    .over_o     (v_over),
    .fill_o     (v_fill),
    .flips_o    (v_flips)
  );

  // session control
  always_comb begin
    state_d = state_q;
    if (start_acc) begin
      state_d = ST_RUN;
    end else if (finish) begin
      state_d = ST_IDLE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  // result capture
  always_comb begin
    done_d   = finish;
    res_en   = start_acc | finish;
    uncorr_d = 1'b0;
    fill_d   = 1'b0;
    flips_d  = '0;
    if (finish) begin
      uncorr_d = v_over;
      fill_d   = v_fill;
      flips_d  = v_flips;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
    end else begin
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      uncorr_q <= 1'b0;
      fill_q   <= 1'b0;
      flips_q  <= '0;
    end else if (res_en) begin
      uncorr_q <= uncorr_d;
      fill_q   <= fill_d;
      flips_q  <= flips_d;
    end
  end

  assign done_o   = done_q;
  assign uncorr_o = uncorr_q;
  assign fill_o   = fill_q;
  assign flips_o  = flips_q;

endmodule

// File: rtl/eras_detect_chk.sv
module eras_detect_chk #(
  parameter int CNT_W  = 4,
  parameter int THRESH = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             byte_valid_i,
  input logic             done_o,
  input logic             uncorr_o,
  input logic             fill_o,
  input logic [CNT_W-1:0] flips_o
);

  // R10: a result pulse never lasts two cycles
  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R7: an uncorrectable verdict never asks for a fill
  p_no_fill_uncorr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uncorr_o |-> !fill_o);

  // R6: a fill request implies some data zeros were seen
  p_fill_nonzero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_o |-> (flips_o != '0));

  // R5: reported count never exceeds the threshold
  p_flips_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(flips_o) <= THRESH);

  // R8: a result follows a streamed byte
  p_done_after_byte_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(byte_valid_i));

  // R8: results hold between sessions
  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!done_o && !$past(start_i)) |-> ($stable(flips_o) && $stable(uncorr_o) && $stable(fill_o)));

endmodule

bind eras_detect eras_detect_chk #(.CNT_W(CNT_W), .THRESH(THRESH)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .byte_valid_i (byte_valid_i),
  .done_o       (done_o),
  .uncorr_o     (uncorr_o),
  .fill_o       (fill_o),
  .flips_o      (flips_o)
);

// File: tb/eras_detect_bench.sv
module eras_detect_bench;

  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       start_i;
  logic [3:0] dec_err_i;
  logic       byte_valid_i;
  logic [7:0] byte_i;
  logic       is_check_i;
  logic       byte_last_i;
  logic       done_o, uncorr_o, fill_o;
  logic [3:0] flips_o;

  int checks = 0;
  int failures = 0;

  logic [7:0] sb [0:531];
  logic       sc [0:531];
  int         done_cnt;
  int         done_at;
  logic       r_unc, r_fill;
  logic [3:0] r_flips;

  always #2.5 clk_i = ~clk_i;

  eras_detect u_eras_detect (
    .clk_i (clk_i), .rst_ni (rst_ni), .start_i (start_i), .dec_err_i (dec_err_i),
    .byte_valid_i (byte_valid_i), .byte_i (byte_i), .is_check_i (is_check_i),
    .byte_last_i (byte_last_i), .done_o (done_o), .uncorr_o (uncorr_o),
    .fill_o (fill_o), .flips_o (flips_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic page_fill();
    for (int i = 0; i < 532; i++) begin
      sb[i] = 8'hFF;
      sc[i] = (i >= 512);
    end
  endtask

  task automatic open_session(input int err);
    @(negedge clk_i);
    start_i = 1'b1;
    dec_err_i = 4'(err);
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic observe(input int idx);
    if (done_o) begin
      done_cnt++;
      done_at = idx;
      r_unc = uncorr_o;
      r_fill = fill_o;
      r_flips = flips_o;
    end
  endtask

  task automatic feed(input int n, input bit with_last);
    done_cnt = 0;
    done_at = -1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      observe(i - 1);
      byte_valid_i = 1'b1;
      byte_i = sb[i];
      is_check_i = sc[i];
      byte_last_i = with_last && (i == n - 1);
    end
    @(negedge clk_i);
    observe(n - 1);
    byte_valid_i = 1'b0;
    byte_last_i = 1'b0;
    @(negedge clk_i);
    observe(n);
  endtask

  task automatic t_reset();
    chk("R1 done", done_o, 0);
    chk("R1 uncorr", uncorr_o, 0);
    chk("R1 fill", fill_o, 0);
    chk("R1 flips", flips_o, 0);
  endtask

  task automatic t_clean_page();
    page_fill();
    open_session(12);
    feed(525, 1);
    chk("R5 done count", done_cnt, 1);
    chk("R5 done after last", done_at, 524);
    chk("R5 uncorr", r_unc, 0);
    chk("R6 no fill on zero flips", r_fill, 0);
    chk("R5 flips", r_flips, 0);
  endtask

  task automatic t_boundary_eight();
    page_fill();
    sb[10] = 8'h7F;
    sb[300] = 8'hFC;
    sb[515] = 8'hE0;
    open_session(9);
    feed(525, 1);
    chk("R11 done at last", done_at, 524);
    chk("R11 erased at 8", r_unc, 0);
    chk("R4 data-only flips", r_flips, 3);
    chk("R6 fill requested", r_fill, 1);
  endtask

  task automatic t_check_only();
    page_fill();
    sb[520] = 8'hFC;
    open_session(15);
    feed(525, 1);
    chk("R4 check zeros hidden", r_flips, 0);
    chk("R4 uncorr", r_unc, 0);
    chk("R6 fill low", r_fill, 0);
  endtask

  task automatic t_early_exit();
    page_fill();
    sb[5] = 8'h00;
    sb[7] = 8'hFE;
    open_session(10);
    feed(525, 1);
    chk("R7 early done index", done_at, 7);
    chk("R7 uncorr", r_unc, 1);
    chk("R7 fill low", r_fill, 0);
    chk("R7 flips zero", r_flips, 0);
    chk("R10 single pulse", done_cnt, 1);
    chk("R8 held uncorr", uncorr_o, 1);
  endtask

  task automatic t_sum_across_lanes();
    page_fill();
    sb[0] = 8'hFE;
    sb[520] = 8'h00;
    open_session(11);
    feed(525, 1);
    chk("R7 cross-lane exit index", done_at, 520);
    chk("R7 cross-lane uncorr", r_unc, 1);
  endtask

  task automatic t_byte_count();
    page_fill();
    sb[0] = 8'h5A;
    sb[1] = 8'hFF;
    sc[1] = 1'b1;
    open_session(9);
    feed(2, 1);
    chk("R3 zeros of 0x5A", r_flips, 4);
    chk("R3 done index", done_at, 1);
    chk("R6 fill", r_fill, 1);
  endtask

  task automatic t_gated_start();
    page_fill();
    sb[0] = 8'h00;
    sb[1] = 8'h00;
    open_session(8);
    feed(2, 1);
    chk("R2 no done", done_cnt, 0);
    chk("R2 flips held", flips_o, 4);
    chk("R2 fill held", fill_o, 1);
  endtask

  task automatic t_restart();
    page_fill();
    sb[0] = 8'hC0;
    open_session(13);
    feed(3, 0);
    chk("R9 no done mid-session", done_cnt, 0);
    page_fill();
    sb[2] = 8'hFE;
    open_session(13);
    feed(4, 1);
    chk("R9 tallies cleared", r_flips, 1);
    chk("R9 erased", r_unc, 0);
    chk("R9 done index", done_at, 3);
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_ni = 1'b0;
    start_i = 1'b0;
    dec_err_i = '0;
    byte_valid_i = 1'b0;
    byte_i = '0;
    is_check_i = 1'b0;
    byte_last_i = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    t_reset();
    t_clean_page();
    t_boundary_eight();
    t_check_only();
    t_early_exit();
    t_sum_across_lanes();
    t_byte_count();
    t_gated_start();
    t_restart();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule